// File: doc/BRIEF.md
# Private Cache Victim Writeback Controller

This block retires a victim line from a private first-level cache that takes part in a directory-based MESI-style coherence protocol. When the replacement logic names a victim address, the controller looks up the line's stable state and reacts to it. A clean shared line is dropped with a clean-eviction notice. A modified line is copied, with its data, into one of a few transaction buffer entries, and its cache frame is released in the same cycle. The controller then sends a dirty writeback carrying the line. A frame holding an invalid or absent line is released without any message.

A buffered dirty line stays in its buffer entry until the directory acknowledges the writeback on the response channel. Until then, a forwarded shared or exclusive request that names the line is answered from the buffer. The state lookup port checks the buffers before the cache frames. An address held in neither reads back as not-present, which is a different code from a frame reserved in the Invalid state. Fetching the replacement line is a separate fill transaction. The fill port here only installs lines so that they can later be evicted.

Top module: `l1_evict_ctrl`

## Requirements
- R1: After synchronous reset, every address looks up as not-present (code 0), `fdat_valid` and `proto_err` are low, and no buffer entry is busy.
- R2: Evicting a line in state M (code 3) presents `req_valid` with `req_is_putx`=1, the victim address and its full line data, and it is accepted in the same cycle as `req_ready`. From the next cycle on, the address looks up as M_I (code 4).
- R3: Evicting a line in state S (code 2) presents `req_valid` with `req_is_putx`=0 and all-zero `req_data`. From the next cycle on, the address looks up as not-present, and no buffer entry is used.
- R4: A writeback acknowledgement whose address matches a busy buffer entry frees that entry. From the next cycle on, the address looks up as not-present.
- R5: A writeback acknowledgement that matches no busy buffer entry raises `proto_err` for the following cycle, one cycle per such acknowledgement, and changes no lookup result.
- R6: A forwarded request that names a busy buffer entry gives, one cycle later, `fdat_valid` with that entry's data and address and the request's exclusive flag. The entry stays busy.
- R7: A forwarded request that names no busy buffer entry produces no `fdat_valid`.
- R8: The lookup reports M_I when the address is in a busy buffer entry, even if a cache frame also holds it. Otherwise it reports the frame state: I=1, S=2 or M=3. An address with neither a frame nor a buffer entry reports not-present (0). A fill with `fill_state` 2 installs S, 3 installs M, and any other code installs I.
- R9: With all buffer entries busy, an M victim is stalled (`repl_ready`=0, no `req_valid`). An S victim still proceeds.
- R10: With `req_ready` low, S and M victims are stalled. A victim that is absent or in state I is accepted at once, sends no message, and releases its frame.
- R11: A replacement whose address is held in a busy buffer entry is stalled and sends no message.
- R12: When a fill and an accepted eviction hit the same cache set in the same cycle, the fill's line is what the set holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Install a line into its cache set |
| fill_addr | input | ADDR_W | Line address of the fill |
| fill_state | input | 3 | State code for the filled line (2 S, 3 M, other I) |
| fill_data | input | LINE_W | Line data of the fill |
| repl_valid | input | 1 | Victim eviction request |
| repl_addr | input | ADDR_W | Victim line address |
| repl_ready | output | 1 | Eviction request accepted this cycle |
| req_valid | output | 1 | Outgoing eviction message present |
| req_ready | input | 1 | Outgoing request channel can take a message |
| req_is_putx | output | 1 | 1 dirty writeback, 0 clean eviction notice |
| req_addr | output | ADDR_W | Address carried by the message |
| req_data | output | LINE_W | Dirty line data (zero for clean notices) |
| ack_valid | input | 1 | Writeback acknowledgement at the head of the response queue (popped this cycle) |
| ack_addr | input | ADDR_W | Address of the acknowledgement |
| fwd_valid | input | 1 | Forwarded coherence request |
| fwd_excl | input | 1 | 1 exclusive (GETX), 0 shared (GETS) |
| fwd_addr | input | ADDR_W | Address of the forwarded request |
| fdat_valid | output | 1 | Data response from a transaction buffer |
| fdat_excl | output | 1 | Exclusive flag echoed from the forwarded request |
| fdat_addr | output | ADDR_W | Address of the data response |
| fdat_data | output | LINE_W | Buffered line data |
| proto_err | output | 1 | Acknowledgement matched no pending writeback |
| lk_addr | input | ADDR_W | Address to look up |
| lk_state | output | 3 | Lookup result: 0 NP, 1 I, 2 S, 3 M, 4 M_I |

## Verification
The bench builds the controller with 8-bit addresses, 64-bit lines, 8 cache sets and 4 buffer entries. It draws addresses from a pool of 16 that covers every set twice. The narrow lines keep random data cheap to compare. With only 16 addresses, set conflicts, fills colliding with evictions, acknowledgements racing forwarded requests and a completely full buffer array all come up often. Keeping the default of 4 buffer entries means the full-buffer stall is reached after four dirty evictions. A reference model in the bench predicts every output each cycle.

// File: rtl/evict_pkg.sv
// Package: shared state encodings for the victim writeback controller.
// Assumes: lookup codes are visible on a port, so their values are fixed.
package evict_pkg;

    // Lookup result presented on the lk_state port
    typedef enum logic [2:0] {
        LK_NP = 3'd0,
        LK_I  = 3'd1,
        LK_S  = 3'd2,
        LK_M  = 3'd3,
        LK_MI = 3'd4
    } lk_state_e;

    // Stable state kept in a cache frame
    typedef enum logic [1:0] {
        FR_I = 2'd0,
        FR_S = 2'd1,
        FR_M = 2'd2
    } frame_state_e;

    // State of one transaction buffer entry
    typedef enum logic {
        TBE_FREE = 1'b0,
        TBE_MI   = 1'b1
    } tbe_state_e;

    // Map the fill-port state code onto a frame state
    function automatic frame_state_e decode_fill(input logic [2:0] code);
        frame_state_e st;
        case (code)
            3'd2:    st = FR_S;
            3'd3:    st = FR_M;
            default: st = FR_I;
        endcase
        return st;
    endfunction

    // Map a frame state onto the lookup code
    function automatic lk_state_e frame_to_lk(input frame_state_e st);
        lk_state_e r;
        case (st)
            FR_S:    r = LK_S;
            FR_M:    r = LK_M;
            default: r = LK_I;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evict_frame_array.sv
// Module: direct-mapped cache frame store (presence, tag, state, line data).
// Offers one write port (fill), one clear port (eviction) and two tag-compare
// read ports. A write and a clear to the same set in one cycle: write wins.
// Assumes: NUM_SETS is a power of two, at least 2; data needs no reset
// because presence guards every read.
module evict_frame_array
    import evict_pkg::*;
#(
    parameter int ADDR_W   = 26,
    parameter int LINE_W   = 512,
    parameter int NUM_SETS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  frame_state_e      wr_state,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] va_addr,
    output logic              va_hit,
    output frame_state_e      va_state,
    output logic [LINE_W-1:0] va_data,
    input  logic [ADDR_W-1:0] vb_addr,
    output logic              vb_hit,
    output frame_state_e      vb_state
);

    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [NUM_SETS-1:0] present_q;
    logic [TAG_W-1:0]    tag_q   [NUM_SETS];
    frame_state_e        state_q [NUM_SETS];
    logic [LINE_W-1:0]   data_q  [NUM_SETS];

    logic [IDX_W-1:0] wr_idx, clr_idx, va_idx, vb_idx;

    assign wr_idx  = wr_addr[IDX_W-1:0];
    assign clr_idx = clr_addr[IDX_W-1:0];
    assign va_idx  = va_addr[IDX_W-1:0];
    assign vb_idx  = vb_addr[IDX_W-1:0];

    // Presence bits: clear on eviction, set on fill; fill is applied last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= '0;
        end else begin
            if (clr_en) present_q[clr_idx] <= 1'b0;
            if (wr_en)  present_q[wr_idx]  <= 1'b1;
        end
    end

    // Tag, state and line payload written by a fill
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]   <= wr_addr[ADDR_W-1:IDX_W];
            state_q[wr_idx] <= wr_state;
            data_q[wr_idx]  <= wr_data;
        end
    end

    // Victim read port: tag compare plus state and data
    always_comb begin
        va_hit   = present_q[va_idx] && (tag_q[va_idx] == va_addr[ADDR_W-1:IDX_W]);
        va_state = state_q[va_idx];
        va_data  = data_q[va_idx];
    end

    // Lookup read port: tag compare plus state
    always_comb begin
        vb_hit   = present_q[vb_idx] && (tag_q[vb_idx] == vb_addr[ADDR_W-1:IDX_W]);
        vb_state = state_q[vb_idx];
    end

endmodule

// File: rtl/evict_tbe_file.sv
// Module: transaction buffer array holding dirty victims awaiting their
// writeback acknowledgement. Allocates the lowest free entry; releases the
// entry matching an acknowledgement; answers four address queries.
// Assumes: no two busy entries share an address (the top stalls any
// eviction whose address is already buffered).
module evict_tbe_file
    import evict_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int LINE_W  = 512,
    parameter int NUM_TBE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic [ADDR_W-1:0]  alloc_addr,
    input  logic [LINE_W-1:0]  alloc_data,
    input  logic               rel_en,
    input  logic [ADDR_W-1:0]  rel_addr,
    output logic               rel_hit,
    input  logic [ADDR_W-1:0]  fwd_addr,
    output logic               fwd_hit,
    output logic [LINE_W-1:0]  fwd_data,
    input  logic [ADDR_W-1:0]  qa_addr,
    output logic               qa_hit,
    input  logic [ADDR_W-1:0]  qb_addr,
    output logic               qb_hit,
    output logic [NUM_TBE-1:0] busy,
    output logic               full
);

    logic [NUM_TBE-1:0] free_v;
    logic [NUM_TBE-1:0] alloc_sel;
    logic [NUM_TBE-1:0] rel_match, fwd_match, qa_match, qb_match;
    logic [LINE_W-1:0]  ent_data [NUM_TBE];

    // Lowest free entry as a one-hot vector
    always_comb begin
        free_v    = ~busy;
        alloc_sel = free_v & (~free_v + 1'b1);
    end

    for (genvar e = 0; e < NUM_TBE; e++) begin : g_ent
        tbe_state_e        st_q;
        logic [ADDR_W-1:0] addr_q;
        logic [LINE_W-1:0] data_q;

        // Entry state: allocate to M_I, release on matching acknowledgement
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= TBE_FREE;
            end else if (alloc_en && alloc_sel[e]) begin
                st_q <= TBE_MI;
            end else if (rel_en && rel_match[e]) begin
                st_q <= TBE_FREE;
            end
        end

        // Entry payload captured at allocation
        always_ff @(posedge clk) begin
            if (alloc_en && alloc_sel[e]) begin
                addr_q <= alloc_addr;
                data_q <= alloc_data;
            end
        end

        assign busy[e]      = (st_q == TBE_MI);
        assign rel_match[e] = busy[e] && (addr_q == rel_addr);
        assign fwd_match[e] = busy[e] && (addr_q == fwd_addr);
        assign qa_match[e]  = busy[e] && (addr_q == qa_addr);
        assign qb_match[e]  = busy[e] && (addr_q == qb_addr);
        assign ent_data[e]  = data_q;
    end

    // Select the buffered line named by a forwarded request
    always_comb begin
        fwd_data = '0;
        for (int i = 0; i < NUM_TBE; i++) begin
            if (fwd_match[i]) fwd_data = ent_data[i];
        end
    end

    // Query summaries
    always_comb begin
        rel_hit = |rel_match;
        fwd_hit = |fwd_match;
        qa_hit  = |qa_match;
        qb_hit  = |qb_match;
        full    = &busy;
    end

endmodule

// File: rtl/l1_evict_ctrl.sv
// Module: victim writeback controller for a private coherent cache.
// Decides per victim between a clean notice, a dirty writeback through a
// transaction buffer, or a silent drop; serves forwarded requests from
// buffered lines; retires buffers on acknowledgement; reports lookups.
// Assumes: the response queue head is consumed every cycle it is valid;
// the fill of the missing line is a separate transaction on the fill port.
module l1_evict_ctrl
    import evict_pkg::*;
#(
    parameter int ADDR_W   = 26,
    parameter int LINE_W   = 512,
    parameter int NUM_SETS = 64,
    parameter int NUM_TBE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [2:0]        fill_state,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              repl_valid,
    input  logic [ADDR_W-1:0] repl_addr,
    output logic              repl_ready,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_is_putx,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LINE_W-1:0] req_data,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_addr,
    input  logic              fwd_valid,
    input  logic              fwd_excl,
    input  logic [ADDR_W-1:0] fwd_addr,
    output logic              fdat_valid,
    output logic              fdat_excl,
    output logic [ADDR_W-1:0] fdat_addr,
    output logic [LINE_W-1:0] fdat_data,
    output logic              proto_err,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [2:0]        lk_state
);

    logic               va_hit, vb_hit;
    frame_state_e       va_state, vb_state;
    logic [LINE_W-1:0]  va_data;
    logic               rel_hit, fwd_hit, qa_hit, qb_hit, tbe_full;
    logic [LINE_W-1:0]  fwd_data;
    logic [NUM_TBE-1:0] tbe_busy;

    logic vic_dirty, vic_clean, vic_silent, evict_fire;
    lk_state_e lk_code;

    evict_frame_array #(
        .ADDR_W   (ADDR_W),
        .LINE_W   (LINE_W),
        .NUM_SETS (NUM_SETS)
    ) u_frames (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_valid),
        .wr_addr  (fill_addr),
        .wr_state (decode_fill(fill_state)),
        .wr_data  (fill_data),
        .clr_en   (evict_fire && va_hit),
        .clr_addr (repl_addr),
        .va_addr  (repl_addr),
        .va_hit   (va_hit),
        .va_state (va_state),
        .va_data  (va_data),
        .vb_addr  (lk_addr),
        .vb_hit   (vb_hit),
        .vb_state (vb_state)
    );

    evict_tbe_file #(
        .ADDR_W  (ADDR_W),
        .LINE_W  (LINE_W),
        .NUM_TBE (NUM_TBE)
    ) u_tbes (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (evict_fire && vic_dirty),
        .alloc_addr (repl_addr),
        .alloc_data (va_data),
        .rel_en     (ack_valid),
        .rel_addr   (ack_addr),
        .rel_hit    (rel_hit),
        .fwd_addr   (fwd_addr),
        .fwd_hit    (fwd_hit),
        .fwd_data   (fwd_data),
        .qa_addr    (repl_addr),
        .qa_hit     (qa_hit),
        .qb_addr    (lk_addr),
        .qb_hit     (qb_hit),
        .busy       (tbe_busy),
        .full       (tbe_full)
    );

    // Classify the victim and decide message, stall and acceptance
    always_comb begin
        vic_dirty  = va_hit && (va_state == FR_M);
        vic_clean  = va_hit && (va_state == FR_S);
        vic_silent = !vic_dirty && !vic_clean;
        req_valid  = repl_valid && !qa_hit &&
                     (vic_clean || (vic_dirty && !tbe_full));
        repl_ready = !qa_hit &&
                     (vic_silent || (req_ready && (vic_clean || !tbe_full)));
        evict_fire = repl_valid && repl_ready;
    end

    // Outgoing message payload; clean notices carry no data
    always_comb begin
        req_is_putx = vic_dirty;
        req_addr    = repl_addr;
        req_data    = vic_dirty ? va_data : '0;
    end

    // Lookup: buffer state overrides frame state; neither gives not-present
    always_comb begin
        if (qb_hit)      lk_code = LK_MI;
        else if (vb_hit) lk_code = frame_to_lk(vb_state);
        else             lk_code = LK_NP;
        lk_state = lk_code;
    end

    // Forwarded-request data response from a buffered line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fdat_valid <= 1'b0;
            fdat_excl  <= 1'b0;
            fdat_addr  <= '0;
            fdat_data  <= '0;
        end else begin
            fdat_valid <= fwd_valid && fwd_hit;
            fdat_excl  <= fwd_excl;
            fdat_addr  <= fwd_addr;
            fdat_data  <= fwd_data;
        end
    end

    // Flag an acknowledgement that matched no pending writeback
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= ack_valid && !rel_hit;
    end

endmodule

// File: rtl/l1_evict_ctrl_chk.sv
// Module: protocol checker for the victim writeback controller, bound to
// every instance of the top. Observes ports and the buffer busy vector.
module l1_evict_ctrl_chk #(
    parameter int ADDR_W  = 26,
    parameter int LINE_W  = 512,
    parameter int NUM_TBE = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               repl_valid,
    input logic               repl_ready,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_is_putx,
    input logic [LINE_W-1:0]  req_data,
    input logic               ack_valid,
    input logic               fwd_valid,
    input logic [ADDR_W-1:0]  fwd_addr,
    input logic               fdat_valid,
    input logic [ADDR_W-1:0]  fdat_addr,
    input logic               proto_err,
    input logic [NUM_TBE-1:0] tbe_busy
);

    // R3: a clean notice never carries data
    a_r3_clean_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_putx) |-> (req_data == '0));

    // R2: an accepted dirty writeback with no acknowledgement adds one busy entry
    a_r2_putx_takes_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_is_putx && !ack_valid)
        |=> ($countones(tbe_busy) == $countones($past(tbe_busy)) + 1));

    // R5: an error flag is always caused by an acknowledgement one cycle earlier
    a_r5_err_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(ack_valid));

    // R6: a data response follows a forwarded request for the same address
    a_r6_fdat_from_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        fdat_valid |-> ($past(fwd_valid) && (fdat_addr == $past(fwd_addr))));

    // R9: no dirty writeback is offered while every buffer is busy
    a_r9_full_no_putx: assert property (@(posedge clk) disable iff (!rst_n)
        (&tbe_busy) |-> !(req_valid && req_is_putx));

    // R10: a victim that sends a message is only accepted with channel ready
    a_r10_accept_needs_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_valid && repl_ready && req_valid) |-> req_ready);

endmodule

bind l1_evict_ctrl l1_evict_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_W),
    .NUM_TBE (NUM_TBE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .repl_valid  (repl_valid),
    .repl_ready  (repl_ready),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_is_putx (req_is_putx),
    .req_data    (req_data),
    .ack_valid   (ack_valid),
    .fwd_valid   (fwd_valid),
    .fwd_addr    (fwd_addr),
    .fdat_valid  (fdat_valid),
    .fdat_addr   (fdat_addr),
    .proto_err   (proto_err),
    .tbe_busy    (tbe_busy)
);

// File: tb/l1_evict_ctrl_tb.sv
// Bench: directed corner cases then seeded random traffic, checked against
// a reference model of the requirements kept in this module.
module l1_evict_ctrl_tb;

    localparam int AW = 8;
    localparam int LW = 64;
    localparam int NS = 8;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [2:0]    fill_state = '0;
    logic [LW-1:0] fill_data = '0;
    logic          repl_valid = 1'b0;
    logic [AW-1:0] repl_addr = '0;
    logic          repl_ready;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic          req_is_putx;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_data;
    logic          ack_valid = 1'b0;
    logic [AW-1:0] ack_addr = '0;
    logic          fwd_valid = 1'b0;
    logic          fwd_excl = 1'b0;
    logic [AW-1:0] fwd_addr = '0;
    logic          fdat_valid;
    logic          fdat_excl;
    logic [AW-1:0] fdat_addr;
    logic [LW-1:0] fdat_data;
    logic          proto_err;
    logic [AW-1:0] lk_addr = '0;
    logic [2:0]    lk_state;

    always #5 clk = ~clk;

    l1_evict_ctrl #(.ADDR_W(AW), .LINE_W(LW), .NUM_SETS(NS), .NUM_TBE(NT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_state(fill_state), .fill_data(fill_data),
        .repl_valid(repl_valid), .repl_addr(repl_addr), .repl_ready(repl_ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_putx(req_is_putx),
        .req_addr(req_addr), .req_data(req_data),
        .ack_valid(ack_valid), .ack_addr(ack_addr),
        .fwd_valid(fwd_valid), .fwd_excl(fwd_excl), .fwd_addr(fwd_addr),
        .fdat_valid(fdat_valid), .fdat_excl(fdat_excl), .fdat_addr(fdat_addr), .fdat_data(fdat_data),
        .proto_err(proto_err), .lk_addr(lk_addr), .lk_state(lk_state)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    bit          m_pres [NS];
    logic [AW-1:0] m_addr [NS];
    int          m_st   [NS];
    logic [LW-1:0] m_data [NS];
    bit          t_busy [NT];
    logic [AW-1:0] t_addr [NT];
    logic [LW-1:0] t_data [NT];

    bit            e_fdat_v = 1'b0;
    bit            e_fdat_x = 1'b0;
    logic [AW-1:0] e_fdat_a = '0;
    logic [LW-1:0] e_fdat_d = '0;
    bit            e_err = 1'b0;

    task automatic chk(input string tag, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int tbe_find(input logic [AW-1:0] a);
        for (int i = 0; i < NT; i++) if (t_busy[i] && t_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int tbe_count();
        int n = 0;
        for (int i = 0; i < NT; i++) if (t_busy[i]) n++;
        return n;
    endfunction

    function automatic bit frame_hit(input logic [AW-1:0] a);
        int s = int'(a) % NS;
        return m_pres[s] && m_addr[s] == a;
    endfunction

    function automatic int fill_code(input logic [2:0] c);
        if (c == 3'd2) return 2;
        if (c == 3'd3) return 3;
        return 1;
    endfunction

    function automatic logic [2:0] exp_lk(input logic [AW-1:0] a);
        if (tbe_find(a) >= 0) return 3'd4;
        if (frame_hit(a)) return 3'(m_st[int'(a) % NS]);
        return 3'd0;
    endfunction

    // One clock cycle: check registered outputs, drive, check combinational
    // outputs, then advance the model to the state after the coming edge.
    task automatic cycle(input bit fv, input logic [AW-1:0] fa, input logic [2:0] fs,
                         input logic [LW-1:0] fd, input bit rv, input logic [AW-1:0] ra,
                         input bit rr, input bit av, input logic [AW-1:0] aa,
                         input bit wv, input bit wx, input logic [AW-1:0] wa,
                         input logic [AW-1:0] la, input string ltag);
        int  vs, ai, fi, ni;
        bit  vt, fh, dirty, clean, silent, room, e_rv, e_rr;
        @(negedge clk);
        chk("R6 R7", "fdat_valid", LW'(fdat_valid), LW'(e_fdat_v));
        if (e_fdat_v) begin
            chk("R6", "fdat_data", fdat_data, e_fdat_d);
            chk("R6", "fdat_addr", LW'(fdat_addr), LW'(e_fdat_a));
            chk("R6", "fdat_excl", LW'(fdat_excl), LW'(e_fdat_x));
        end
        chk("R5", "proto_err", LW'(proto_err), LW'(e_err));
        fill_valid = fv; fill_addr = fa; fill_state = fs; fill_data = fd;
        repl_valid = rv; repl_addr = ra; req_ready = rr;
        ack_valid = av; ack_addr = aa;
        fwd_valid = wv; fwd_excl = wx; fwd_addr = wa;
        lk_addr = la;
        #1;
        vt     = tbe_find(ra) >= 0;
        fh     = frame_hit(ra);
        vs     = fh ? m_st[int'(ra) % NS] : 0;
        dirty  = (vs == 3);
        clean  = (vs == 2);
        silent = !dirty && !clean;
        room   = tbe_count() < NT;
        e_rv   = rv && !vt && (clean || (dirty && room));
        e_rr   = !vt && (silent || (rr && (clean || room)));
        chk("R9 R10 R11", "repl_ready", LW'(repl_ready), LW'(e_rr));
        chk("R2 R3 R11", "req_valid", LW'(req_valid), LW'(e_rv));
        if (e_rv) begin
            chk("R2 R3", "req_is_putx", LW'(req_is_putx), LW'(dirty));
            chk("R2", "req_addr", LW'(req_addr), LW'(ra));
            chk("R2 R3", "req_data", req_data, dirty ? m_data[int'(ra) % NS] : '0);
        end
        chk(ltag, "lk_state", LW'(lk_state), LW'(exp_lk(la)));
        // registered expectations for the next cycle
        fi = tbe_find(wa);
        e_fdat_v = wv && fi >= 0;
        e_fdat_x = wx;
        e_fdat_a = wa;
        e_fdat_d = (fi >= 0) ? t_data[fi] : '0;
        ai = tbe_find(aa);
        e_err = av && ai < 0;
        // model update
        ni = -1;
        for (int i = NT - 1; i >= 0; i--) if (!t_busy[i]) ni = i;
        if (rv && e_rr && dirty) begin
            t_busy[ni] = 1'b1; t_addr[ni] = ra; t_data[ni] = m_data[int'(ra) % NS];
        end
        if (av && ai >= 0) t_busy[ai] = 1'b0;
        if (rv && e_rr && fh) m_pres[int'(ra) % NS] = 1'b0;
        if (fv) begin
            m_pres[int'(fa) % NS] = 1'b1;
            m_addr[int'(fa) % NS] = fa;
            m_st[int'(fa) % NS]   = fill_code(fs);
            m_data[int'(fa) % NS] = fd;
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input logic [2:0] s, input logic [LW-1:0] d,
                           input logic [AW-1:0] la, input string tag);
        cycle(1, a, s, d, 0, '0, 1, 0, '0, 0, 0, '0, la, tag);
    endtask

    task automatic do_repl(input logic [AW-1:0] a, input bit rr, input logic [AW-1:0] la, input string tag);
        cycle(0, '0, '0, '0, 1, a, rr, 0, '0, 0, 0, '0, la, tag);
    endtask

    task automatic do_ack(input logic [AW-1:0] a, input logic [AW-1:0] la, input string tag);
        cycle(0, '0, '0, '0, 0, '0, 1, 1, a, 0, 0, '0, la, tag);
    endtask

    task automatic do_fwd(input logic [AW-1:0] a, input bit x, input logic [AW-1:0] la, input string tag);
        cycle(0, '0, '0, '0, 0, '0, 1, 0, '0, 1, x, a, la, tag);
    endtask

    task automatic do_idle(input logic [AW-1:0] la, input string tag);
        cycle(0, '0, '0, '0, 0, '0, 1, 0, '0, 0, 0, '0, la, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < NS; i++) begin m_pres[i] = 0; m_addr[i] = '0; m_st[i] = 0; m_data[i] = '0; end
        for (int i = 0; i < NT; i++) begin t_busy[i] = 0; t_addr[i] = '0; t_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "fdat_valid", LW'(fdat_valid), '0);
        chk("R1", "proto_err", LW'(proto_err), '0);
        for (int a = 0; a < 16; a++) begin
            lk_addr = AW'(a);
            #1;
            chk("R1", "lk_state", LW'(lk_state), '0);
        end

        // R2: dirty eviction through a buffer
        do_fill(8'h03, 3'd3, 64'hA5A5_0000_1234_5678, 8'h03, "R8");
        do_repl(8'h03, 1, 8'h03, "R8");
        do_idle(8'h03, "R2");
        // R6: forwarded request served from buffer, entry kept
        do_fwd(8'h03, 1, 8'h03, "R6");
        do_fwd(8'h03, 0, 8'h03, "R6");
        // R7: forwarded request miss
        do_fwd(8'h05, 1, 8'h03, "R7");
        // R5: unmatched acknowledgement
        do_ack(8'h05, 8'h03, "R5");
        do_idle(8'h03, "R5");
        // R4: matching acknowledgement frees the buffer
        do_ack(8'h03, 8'h03, "R4");
        do_idle(8'h03, "R4");
        // R3 and R10: clean eviction, stalled then sent
        do_fill(8'h0A, 3'd2, 64'h1111, 8'h0A, "R8");
        do_repl(8'h0A, 0, 8'h0A, "R10");
        do_repl(8'h0A, 1, 8'h0A, "R3");
        do_idle(8'h0A, "R3");
        // R8 and R10: Invalid frame differs from not-present, drops silently
        do_fill(8'h11, 3'd1, 64'h2222, 8'h11, "R8");
        do_idle(8'h11, "R8");
        do_repl(8'h11, 0, 8'h11, "R10");
        do_idle(8'h11, "R10");
        // R9: fill every buffer, then dirty stalls, clean proceeds
        for (int i = 0; i < 4; i++) begin
            do_fill(AW'(8'h20 + i), 3'd3, {$urandom, $urandom}, AW'(8'h20 + i), "R8");
            do_repl(AW'(8'h20 + i), 1, AW'(8'h20 + i), "R2");
        end
        do_fill(8'h24, 3'd3, 64'h3333, 8'h24, "R9");
        do_repl(8'h24, 1, 8'h24, "R9");
        do_fill(8'h25, 3'd2, 64'h4444, 8'h25, "R9");
        do_repl(8'h25, 1, 8'h25, "R9");
        // R11: refilled address still buffered: stall and buffer wins lookup
        do_fill(8'h20, 3'd2, 64'h5555, 8'h20, "R8");
        do_repl(8'h20, 1, 8'h20, "R11");
        do_idle(8'h20, "R8");
        for (int i = 0; i < 4; i++) do_ack(AW'(8'h20 + i), AW'(8'h20 + i), "R4");
        // R12: fill and eviction on the same set in one cycle
        do_fill(8'h07, 3'd2, 64'h6666, 8'h07, "R8");
        cycle(1, 8'h0F, 3'd3, 64'h7777, 1, 8'h07, 1, 0, '0, 0, 0, '0, 8'h0F, "R12");
        do_idle(8'h0F, "R12");
        do_idle(8'h07, "R12");

        // Seeded random traffic over a 16-address pool
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom % 10) < 3, AW'($urandom % 16), 3'($urandom % 5), {$urandom, $urandom},
                  ($urandom % 10) < 4, AW'($urandom % 16), ($urandom % 4) != 0,
                  ($urandom % 4) == 0, AW'($urandom % 16),
                  ($urandom % 4) == 0, 1'($urandom % 2), AW'($urandom % 16),
                  AW'($urandom % 16), "R8");
        end
        do_idle('0, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule